// File: doc/BRIEF.md
# Timer Count-Clock and Clear-Edge Selector

This block sits in front of two timer counters. It turns the system clock, or an external clock pin, into one-cycle count-enable strobes for each channel. It also turns an external clear pin into a one-cycle clear strobe that both channels share. A 16-bit control word sets the behaviour. For each channel the word picks one of seven prescaled system-clock taps or the external pin, and picks which edge of that source counts: falling, rising or both. The word also picks which edge of the clear pin fires the clear strobe, or switches clearing off.

A single free-running prescaler supplies every tap. Each tap is a square wave, and its edges are found synchronously in the system clock domain. Both external pins pass through a two-flop synchronizer before their edges are detected. Each edge qualifier is a small state machine with three states:
- `ST_PRIME`: reloads the edge history after reset or after leaving the muted state.
- `ST_ARMED`: detects edges.
- `ST_MUTED`: entered while the edge code is the disabled code 10.

The transitions are:
- PRIME→ARMED when the code is not 10.
- PRIME→MUTED and ARMED→MUTED when the code is 10.
- MUTED→PRIME when the code leaves 10.
- ARMED→PRIME when the channel's clock select changes. In that cycle no strobe is produced.

Top module: `tmr_clksel_edge`

## Requirements
- R1: After reset the control word reads 0x0000 and all strobes are low. Bits 15..12 always read 0, and writes to them have no effect.
- R2: The write kind selects how a write is applied:
  - `wr_kind` 0 replaces the whole word from `wr_data[15:0]`.
  - `wr_kind` 1 writes bits 7..0 from `wr_data[7:0]`.
  - `wr_kind` 2 writes bits 15..8 from `wr_data[7:0]`.
  - `rd_data` shows the word on the cycle after the write.
- R3: `wr_kind` 3 writes `wr_data[0]` into the single bit indexed by `wr_bit`. Every other bit is left unchanged.
- R4: The clock-select field is bits 2..0 for channel 0 and bits 5..3 for channel 1. Codes 0 to 6 pick the system clock divided by 2, 4, 8, 16, 32, 64 and 128, each taken from one free-running prescaler.
- R5: The edge field is bits 9..8 for channel 0 and bits 11..10 for channel 1. Codes are 00 falling, 01 rising and 11 both edges. Every qualifying edge gives exactly one strobe, one cycle wide.
- R6: Clock-select code 7 picks the synchronized external clock pin. A pin change gives its strobe on the third rising system-clock edge after the change.
- R7: Edge code 10 for a channel produces no count strobes on that channel.
- R8: Bits 7..6 select the clear-pin edge. Codes are 00 falling, 01 rising and 11 both, with the same latency as R6. Code 10 passes the pin through and produces no clear strobe.
- R9: Changing a channel's clock select produces no strobe that is caused by the switch itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_kind | input | 2 | 0 word, 1 low byte, 2 high byte, 3 single bit |
| wr_bit | input | 4 | Bit index for single-bit writes |
| wr_data | input | 16 | Write data (byte writes use bits 7..0, bit writes use bit 0) |
| rd_data | output | 16 | Current control word |
| ext_clk_pin | input | 1 | External count clock pin, asynchronous |
| ext_clr_pin | input | 1 | External clear pin, asynchronous |
| cnt_strobe | output | 2 | Per-channel count-enable strobes |
| clr_strobe | output | 1 | Shared clear strobe |

## Verification
A wrong prescaler phase or a wrong tap mux shows as a wrong number of strobes in any window of 256 cycles, visible within one such window after the setting changes. Broken edge history or a broken edge-mode decode shows either as a strobe in the wrong sample, which is exactly three cycles after a pin change, or as a strobe pair where one is expected. A missing history reload on a select change shows as a strobe within two cycles of the write, even though the selected source is steady.

// File: rtl/tce_pkg.sv
package tce_pkg;
    typedef enum logic [1:0] {
        WR_WORD = 2'd0,
        WR_LOW  = 2'd1,
        WR_HIGH = 2'd2,
        WR_BIT  = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_OFF  = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_ARMED = 2'd1,
        ST_MUTED = 2'd2
    } edge_state_e;

    localparam int          CTRL_W    = 16;
    localparam logic [15:0] LIVE_BITS = 16'h0FFF;
endpackage

// File: rtl/tce_ctrl_reg.sv
module tce_ctrl_reg
    import tce_pkg::*;
#(
    parameter int          W         = 16,
    parameter logic [15:0] LIVE_MASK = 16'h0FFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [$clog2(W)-1:0] wr_bit,
    input  logic [W-1:0]         wr_data,
    output logic [W-1:0]         ctrl
);
    localparam int HALF = W / 2;

    logic [W-1:0] ctrl_nxt;

    always_comb begin
        ctrl_nxt = ctrl;
        if (wr_en) begin
            unique case (wr_kind)
                WR_WORD: ctrl_nxt = wr_data;
                WR_LOW:  ctrl_nxt[HALF-1:0] = wr_data[HALF-1:0];
                WR_HIGH: ctrl_nxt[W-1:HALF] = wr_data[HALF-1:0];
                WR_BIT:  ctrl_nxt[wr_bit] = wr_data[0];
                default: ctrl_nxt = ctrl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl <= '0;
        else        ctrl <= ctrl_nxt & LIVE_MASK[W-1:0];
    end

    // R2: a low-byte write leaves the high byte alone
    a_r2_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WR_LOW) |=> (ctrl[W-1:HALF] == $past(ctrl[W-1:HALF])));

    // R3: a single-bit write touches at most one bit
    a_r3_one_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WR_BIT) |=> ($countones(ctrl ^ $past(ctrl)) <= 1));
endmodule

// File: rtl/tce_prescaler.sv
module tce_prescaler #(
    parameter int STAGES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] taps
);
    logic [STAGES-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign taps = cnt;

    // R4: the prescaler advances by one every cycle out of reset
    a_r4_prescale_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == STAGES'($past(cnt) + 1'b1)));
endmodule

// File: rtl/tce_sync2.sv
module tce_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tce_edge_qual.sv
module tce_edge_qual
    import tce_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       mode,
    output logic             strobe
);
    edge_state_e      state, state_nxt;
    logic             prev;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;
    logic             hit;
    logic             strobe_d;

    assign sel_chg = (sel != sel_q);

    always_comb begin
        unique case (mode)
            EDGE_FALL: hit = prev & ~level;
            EDGE_RISE: hit = ~prev & level;
            EDGE_BOTH: hit = prev ^ level;
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PRIME: state_nxt = (mode == EDGE_OFF) ? ST_MUTED : ST_ARMED;
            ST_ARMED: begin
                if (mode == EDGE_OFF) state_nxt = ST_MUTED;
                else if (sel_chg)     state_nxt = ST_PRIME;
            end
            ST_MUTED: if (mode != EDGE_OFF) state_nxt = ST_PRIME;
            default:  state_nxt = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nxt;
    end

    always_comb begin
        strobe_d = (state == ST_ARMED) && !sel_chg && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev   <= 1'b0;
            sel_q  <= '0;
            strobe <= 1'b0;
        end else begin
            prev   <= level;
            sel_q  <= sel;
            strobe <= strobe_d;
        end
    end

    // R5: a single-edge mode never gives back-to-back strobes
    a_r5_single_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mode != EDGE_BOTH && $stable(mode) && $stable(sel)) |=> !strobe);

    // R7: a muted qualifier stays silent
    a_r7_muted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF && $past(mode) == EDGE_OFF) |-> !strobe);

    // R9: switching the source never strobes in the next cycle
    a_r9_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |=> !strobe);
endmodule

// File: rtl/tmr_clksel_edge.sv
module tmr_clksel_edge
    import tce_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_kind,
    input  logic [3:0]  wr_bit,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        ext_clk_pin,
    input  logic        ext_clr_pin,
    output logic [1:0]  cnt_strobe,
    output logic        clr_strobe
);
    localparam int NUM_SRC   = 2 ** SEL_W;
    localparam int NUM_TAPS  = NUM_SRC - 1;
    localparam int EDGE_BASE = 8;
    localparam int CLR_LSB   = 6;

    logic [CTRL_W-1:0]   ctrl;
    logic [NUM_TAPS-1:0] taps;
    logic [1:0]          pins_s;
    logic                ext_clk_s;
    logic                ext_clr_s;

    tce_ctrl_reg #(.W(CTRL_W), .LIVE_MASK(LIVE_BITS)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_bit  (wr_bit),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    tce_prescaler #(.STAGES(NUM_TAPS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps)
    );

    tce_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_clr_pin, ext_clk_pin}),
        .q     (pins_s)
    );

    assign ext_clk_s = pins_s[0];
    assign ext_clr_s = pins_s[1];
    assign rd_data   = ctrl;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [SEL_W-1:0]   sel;
        logic [1:0]         mode;
        logic [NUM_SRC-1:0] src;
        logic               lvl;

        assign sel  = ctrl[ch*SEL_W +: SEL_W];
        assign mode = ctrl[EDGE_BASE + 2*ch +: 2];
        assign src  = {ext_clk_s, taps};
        assign lvl  = src[sel];

        tce_edge_qual #(.SEL_W(SEL_W)) u_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (lvl),
            .sel    (sel),
            .mode   (mode),
            .strobe (cnt_strobe[ch])
        );
    end

    tce_edge_qual #(.SEL_W(1)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (ext_clr_s),
        .sel    (1'b0),
        .mode   (ctrl[CLR_LSB +: 2]),
        .strobe (clr_strobe)
    );

    // R8: pass-through clear mode never clears
    a_r8_clear_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CLR_LSB +: 2] == 2'b10 && $past(ctrl[CLR_LSB +: 2]) == 2'b10) |-> !clr_strobe);

    // R1: unused upper bits never read back as one
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data[15:12] == 4'h0));
endmodule

// File: tb/tb_tmr_clksel_edge.sv
module tb_tmr_clksel_edge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_kind;
    logic [3:0]  wr_bit;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        ext_clk_pin;
    logic        ext_clr_pin;
    logic [1:0]  cnt_strobe;
    logic        clr_strobe;

    int          total = 0;
    int          bad   = 0;
    logic [15:0] model;

    always #5 clk = ~clk;

    tmr_clksel_edge dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_bit(wr_bit), .wr_data(wr_data), .rd_data(rd_data),
        .ext_clk_pin(ext_clk_pin), .ext_clr_pin(ext_clr_pin),
        .cnt_strobe(cnt_strobe), .clr_strobe(clr_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] apply(input logic [15:0] old, input logic [1:0] k,
                                          input logic [3:0] b, input logic [15:0] d);
        logic [15:0] r = old;
        case (k)
            2'd0: r = d;
            2'd1: r[7:0] = d[7:0];
            2'd2: r[15:8] = d[7:0];
            default: r[b] = d[0];
        endcase
        return r & 16'h0FFF;
    endfunction

    function automatic int exp_count(input int code, input int mode, input int win);
        int div = 2 << code;
        if (code == 7 || mode == 2) return 0;
        if (mode == 3) return (2 * win) / div;
        return win / div;
    endfunction

    task automatic wr(input logic [1:0] k, input logic [3:0] b, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_bit = b; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model = apply(model, k, b, d);
    endtask

    task automatic count_all(input int n, output int c0, output int c1, output int cl);
        c0 = 0; c1 = 0; cl = 0;
        repeat (n) begin
            @(negedge clk);
            c0 += int'(cnt_strobe[0]);
            c1 += int'(cnt_strobe[1]);
            cl += int'(clr_strobe);
        end
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // pulse both pins high for 6 samples, then low for 6; record samples
    task automatic pin_pulse(output logic [5:0] r0, output logic [5:0] r1, output logic [5:0] rc,
                             output logic [5:0] f0, output logic [5:0] f1, output logic [5:0] fc);
        @(negedge clk);
        ext_clk_pin = 1'b1; ext_clr_pin = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            r0[i] = cnt_strobe[0]; r1[i] = cnt_strobe[1]; rc[i] = clr_strobe;
        end
        ext_clk_pin = 1'b0; ext_clr_pin = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            f0[i] = cnt_strobe[0]; f1[i] = cnt_strobe[1]; fc[i] = clr_strobe;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int c0, c1, cl;
        logic [5:0] r0, r1, rc, f0, f1, fc;
        void'($urandom(32'd20240611));
        model = 16'h0000;
        rst_n = 1'b0; wr_en = 1'b0; wr_kind = 2'd0; wr_bit = 4'd0; wr_data = 16'h0;
        ext_clk_pin = 1'b0; ext_clr_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset word", int'(rd_data), 0);
        check("R1 reset strobes", int'({cnt_strobe, clr_strobe}), 0);
        rst_n = 1'b1;

        // register access
        wr(2'd0, 4'd0, 16'hFFFF);
        check("R1 upper bits read zero", int'(rd_data), 16'h0FFF);
        wr(2'd1, 4'd0, 16'h0012);
        check("R2 low byte write", int'(rd_data), 16'h0F12);
        wr(2'd2, 4'd0, 16'h00AB);
        check("R2 high byte write", int'(rd_data), 16'h0B12);
        wr(2'd3, 4'd13, 16'h0001);
        check("R1 bit write to bit 13 ignored", int'(rd_data), 16'h0B12);
        wr(2'd3, 4'd4, 16'h0001);
        check("R3 single bit set", int'(rd_data), 16'h0B12 | 16'h0010);
        wr(2'd3, 4'd1, 16'h0000);
        check("R3 single bit clear", int'(rd_data), int'(model));

        // R4/R5: every tap, ch0 rising, ch1 falling
        for (int c = 0; c < 7; c++) begin
            wr(2'd0, 4'd0, 16'((0 << 10) | (1 << 8) | (3 << 6) | (c << 3) | c));
            repeat (8) @(negedge clk);
            count_all(256, c0, c1, cl);
            check($sformatf("R4 R5 ch0 rising tap %0d", c), c0, exp_count(c, 1, 256));
            check($sformatf("R4 R5 ch1 falling tap %0d", c), c1, exp_count(c, 0, 256));
        end
        // R5 both edges, R7 muted
        wr(2'd0, 4'd0, 16'((3 << 10) | (2 << 8) | (1 << 3) | 0));
        repeat (8) @(negedge clk);
        count_all(256, c0, c1, cl);
        check("R7 ch0 muted", c0, 0);
        check("R5 ch1 both edges tap 1", c1, exp_count(1, 3, 256));

        // R6/R8: external pins, ch0 rising, ch1 falling, clear both
        wr(2'd0, 4'd0, 16'h01FF);
        repeat (6) @(negedge clk);
        pin_pulse(r0, r1, rc, f0, f1, fc);
        check("R6 ch0 rise at third edge", int'(r0), 6'b000100);
        check("R6 ch0 no strobe on fall", int'(f0), 0);
        check("R6 ch1 no strobe on rise", int'(r1), 0);
        check("R6 ch1 fall at third edge", int'(f1), 6'b000100);
        check("R8 clear both on rise", int'(rc), 6'b000100);
        check("R8 clear both on fall", int'(fc), 6'b000100);
        // R8 rising-only clear
        wr(2'd0, 4'd0, 16'h017F);
        repeat (6) @(negedge clk);
        pin_pulse(r0, r1, rc, f0, f1, fc);
        check("R8 clear rising on rise", int'(rc), 6'b000100);
        check("R8 clear rising on fall", int'(fc), 0);
        // R8 pass-through
        wr(2'd0, 4'd0, 16'h01BF);
        repeat (6) @(negedge clk);
        pin_pulse(r0, r1, rc, f0, f1, fc);
        check("R8 passthrough rise", int'(rc), 0);
        check("R8 passthrough fall", int'(fc), 0);

        // R9: switch from /2 tap to a steady-high pin must stay quiet
        @(negedge clk);
        ext_clk_pin = 1'b1;
        for (int off = 0; off < 2; off++) begin
            wr(2'd0, 4'd0, 16'h0100);
            repeat (4 + off) @(negedge clk);
            wr(2'd0, 4'd0, 16'h0107);
            @(posedge clk);
            count_all(10, c0, c1, cl);
            check($sformatf("R9 no strobe after switch offset %0d", off), c0, 0);
        end
        @(negedge clk);
        ext_clk_pin = 1'b0;
        repeat (4) @(negedge clk);

        // constrained random settings
        for (int it = 0; it < 10; it++) begin
            int s0 = int'($urandom_range(7, 0));
            int s1 = int'($urandom_range(7, 0));
            int m0 = int'($urandom_range(3, 0));
            int m1 = int'($urandom_range(3, 0));
            int cm = int'($urandom_range(3, 0));
            logic [15:0] w = 16'((m1 << 10) | (m0 << 8) | (cm << 6) | (s1 << 3) | s0);
            wr(2'd0, 4'd0, w | 16'hF000);
            check("R2 random word", int'(rd_data), int'(w));
            repeat (8) @(negedge clk);
            count_all(256, c0, c1, cl);
            check($sformatf("R4 R5 R7 random ch0 sel=%0d mode=%0d", s0, m0), c0, exp_count(s0, m0, 256));
            check($sformatf("R4 R5 R7 random ch1 sel=%0d mode=%0d", s1, m1), c1, exp_count(s1, m1, 256));
            check("R8 steady clear pin no clear", cl, 0);
        end

        finish_run();
    end
endmodule